// File: doc/BRIEF.md
# Seconds-Count Real-Time Clock with Alarm

This peripheral keeps a running count of elapsed seconds in a 32-bit register and compares it with a 32-bit alarm value. When they meet, it raises a single-cycle interrupt. A prescaler divides an external tick enable down to one-second steps. Software reaches every register through a plain 32-bit bus with address, write strobe, write data and combinational read data.

The control and charger-control registers use a masked-write convention. The upper half of the write word selects which low bits a write may change, so one bit can be set or cleared without reading the register first. Two resets drive the block. The power-on reset clears everything. The system reset clears only the time-keeping registers, and skips them when software has set the retention bit. The charger-control register only drives configuration pins toward an analog charger that sits outside this block.

Top module: `sec_rtc`

## Requirements
- R1: Power-on reset (`por_rst`, synchronous, active high) clears the seconds count, alarm, user word, trim, control, charger control and reset record. It also clears both interrupt outputs and sets the divider to `DIV_RESET` (32767).
- R2: The control register sits at offset 0x40 and reads back in bits [5:0]. The bits are: bit0 alarm enable, bit1 wake-request enable, bit2 late-arm enable, bit3 oscillator-mode reset flag, bit4 retain-through-system-reset and bit5 freeze. A write changes bit n only when write-data bit n+16 is 1.
- R3: The charger register at 0x5C uses the same mask rule with bits 16..19. Its fields are bit0 enable, bit1 diode bypass and bits [3:2] resistor code. The fields drive `chg_en`, `chg_no_diode` and `chg_rsel`.
- R4: A write to 0x4C loads the seconds count with the full write word. Offset 0x44 returns the live count. Offset 0x4C reads as zero.
- R5: With `tick_en` held high, the count advances by one every divider+1 ticks, using the divider value at 0x48. The count wraps from 0xFFFFFFFF to 0.
- R6: While control bit5 is 1, the count holds its value and the prescaler keeps running.
- R7: Certain conditions raise `alarm_irq` for exactly one clock, one cycle after they become true. The conditions are: control bit0 is set, the alarm register at 0x50 is nonzero, and the count equals it. A match that stays true yields one pulse. An alarm value of 0 never fires.
- R8: If bits 0 and 2 are both set when the alarm becomes armed and the count is already above the alarm value, one pulse is raised.
- R9: `alarm_wake` pulses together with `alarm_irq`, but only while control bit1 is 1.
- R10: While `sys_rst` is high, bus writes are ignored and the count does not advance. If bit4 is 1, the count, alarm and user word are kept; if bit4 is 0, they are cleared. Control, divider, charger and trim are never touched by `sys_rst`.
- R11: Bit0 of the reset record at 0x58 becomes 1 when `sys_rst` occurs with bit4 set. Writing 1 to bit0 clears it, and writing 0 has no effect.
- R12: The alarm (0x50), user word (0x54) and trim (0x60) take full-word writes and read back. Any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_rst | input | 1 | Power-on reset, clears all state |
| sys_rst | input | 1 | System reset, honours the retention bit |
| tick_en | input | 1 | One prescaler tick per high cycle |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, mask in [31:16] for masked registers |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| alarm_irq | output | 1 | One-cycle alarm pulse |
| alarm_wake | output | 1 | One-cycle wake request to power control |
| chg_en | output | 1 | Charger enable |
| chg_no_diode | output | 1 | Charger diode bypass |
| chg_rsel | output | 2 | Charger resistor code |

## Verification
The hardest situations to reach are those where the alarm condition stays true, or becomes true by a route other than counting. The bench reaches a held match by freezing the count and loading it directly onto the alarm value, then checks that only one pulse appears. It reaches the late-arm case by loading a count above the alarm and then enabling the alarm. Retention is exercised by asserting the system reset with the retention bit set and issuing a bus write during it, then repeating with the bit clear. A behavioural model in the bench follows every clock and is compared on each cycle.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

    localparam int REG_W  = 32;
    localparam int HALF_W = 16;

    localparam logic [31:0] OFS_CTRL  = 32'h40;
    localparam logic [31:0] OFS_NOW   = 32'h44;
    localparam logic [31:0] OFS_DIV   = 32'h48;
    localparam logic [31:0] OFS_TSET  = 32'h4C;
    localparam logic [31:0] OFS_ALARM = 32'h50;
    localparam logic [31:0] OFS_USER  = 32'h54;
    localparam logic [31:0] OFS_RREC  = 32'h58;
    localparam logic [31:0] OFS_CHG   = 32'h5C;
    localparam logic [31:0] OFS_TRIM  = 32'h60;

    // bit5 .. bit0
    typedef struct packed {
        logic freeze;
        logic keep;
        logic osc_rst;
        logic late_en;
        logic wake_en;
        logic alarm_en;
    } ctrl_t;

    // bit3 .. bit0
    typedef struct packed {
        logic [1:0] rsel;
        logic       no_diode;
        logic       en;
    } chg_t;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_CTRL, SEL_NOW, SEL_DIV, SEL_TSET,
        SEL_ALARM, SEL_USER, SEL_RREC, SEL_CHG, SEL_TRIM
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [31:0] a);
        case (a)
            OFS_CTRL:  return SEL_CTRL;
            OFS_NOW:   return SEL_NOW;
            OFS_DIV:   return SEL_DIV;
            OFS_TSET:  return SEL_TSET;
            OFS_ALARM: return SEL_ALARM;
            OFS_USER:  return SEL_USER;
            OFS_RREC:  return SEL_RREC;
            OFS_CHG:   return SEL_CHG;
            OFS_TRIM:  return SEL_TRIM;
            default:   return SEL_NONE;
        endcase
    endfunction

    // low half takes new data only where the high half of the word has a 1
    function automatic logic [HALF_W-1:0] mask_merge(input logic [HALF_W-1:0] old_v,
                                                     input logic [REG_W-1:0]  wd);
        return (old_v & ~wd[REG_W-1:HALF_W]) | (wd[HALF_W-1:0] & wd[REG_W-1:HALF_W]);
    endfunction

endpackage

// File: rtl/sec_rtc_prescaler.sv
module sec_rtc_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             tick_en,
    input  logic [DIV_W-1:0] div_val,
    output logic             sec_pulse
);
    logic [DIV_W-1:0] pre_q;
    logic             at_end;

    assign at_end    = (pre_q >= div_val);
    assign sec_pulse = tick_en && !clr && at_end;

    always_ff @(posedge clk) begin
        if (clr) begin
            pre_q <= '0;
        end else if (tick_en) begin
            pre_q <= at_end ? '0 : pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/sec_rtc_counter.sv
module sec_rtc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             por,
    input  logic             wipe,
    input  logic             hold,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (por || wipe) begin
            cnt <= '0;
        end else if (hold) begin
            cnt <= cnt;
        end else if (load) begin
            cnt <= load_val;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sec_rtc_alarm.sv
module sec_rtc_alarm #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] alarm,
    input  logic             alarm_en,
    input  logic             late_en,
    input  logic             wake_en,
    output logic             irq,
    output logic             wake
);
    logic armed, match, late_hit, event_now;
    logic armed_q, match_q;

    assign armed     = alarm_en && (alarm != '0);
    assign match     = armed && (cnt == alarm);
    assign late_hit  = armed && !armed_q && late_en && (cnt > alarm);
    assign event_now = (match && !match_q) || late_hit;

    always_ff @(posedge clk) begin
        if (clr) begin
            armed_q <= 1'b0;
            match_q <= 1'b0;
            irq     <= 1'b0;
            wake    <= 1'b0;
        end else begin
            armed_q <= armed;
            match_q <= match;
            irq     <= event_now;
            wake    <= event_now && wake_en;
        end
    end
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import sec_rtc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int CNT_W     = 32,
    parameter int DIV_W     = 16,
    parameter int DIV_RESET = 32767
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              sys_rst,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              alarm_irq,
    output logic              alarm_wake,
    output logic              chg_en,
    output logic              chg_no_diode,
    output logic [1:0]        chg_rsel
);
    localparam int CTRL_W = $bits(ctrl_t);
    localparam int CHG_W  = $bits(chg_t);
    localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RESET);

    reg_sel_e          sel;
    logic              wr_ok;
    ctrl_t             ctrl_q;
    chg_t              chg_q;
    logic [DIV_W-1:0]  div_q;
    logic [CNT_W-1:0]  alarm_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [31:0]       user_q;
    logic [31:0]       trim_q;
    logic              rec_q;
    logic [HALF_W-1:0] ctrl_merged;
    logic [HALF_W-1:0] chg_merged;
    logic              sec_pulse;
    logic              clr_all;

    assign sel     = decode_ofs(32'(bus_addr));
    assign wr_ok   = bus_we && !sys_rst;
    assign clr_all = por_rst || sys_rst;

    always_comb begin
        ctrl_merged = mask_merge({{(HALF_W-CTRL_W){1'b0}}, ctrl_q}, bus_wdata);
        chg_merged  = mask_merge({{(HALF_W-CHG_W){1'b0}}, chg_q}, bus_wdata);
    end

    always_ff @(posedge clk) begin
        if (por_rst) begin
            ctrl_q  <= '0;
            chg_q   <= '0;
            div_q   <= DIV_INIT;
            alarm_q <= '0;
            user_q  <= '0;
            trim_q  <= '0;
            rec_q   <= 1'b0;
        end else begin
            if (sys_rst && !ctrl_q.keep) begin
                alarm_q <= '0;
                user_q  <= '0;
            end
            if (sys_rst && ctrl_q.keep) begin
                rec_q <= 1'b1;
            end else if (wr_ok && sel == SEL_RREC && bus_wdata[0]) begin
                rec_q <= 1'b0;
            end
            if (wr_ok) begin
                case (sel)
                    SEL_CTRL:  ctrl_q  <= ctrl_t'(ctrl_merged[CTRL_W-1:0]);
                    SEL_CHG:   chg_q   <= chg_t'(chg_merged[CHG_W-1:0]);
                    SEL_DIV:   div_q   <= bus_wdata[DIV_W-1:0];
                    SEL_ALARM: alarm_q <= bus_wdata[CNT_W-1:0];
                    SEL_USER:  user_q  <= bus_wdata;
                    SEL_TRIM:  trim_q  <= bus_wdata;
                    default:   ;
                endcase
            end
        end
    end

    sec_rtc_prescaler #(.DIV_W(DIV_W)) presc_i (
        .clk      (clk),
        .clr      (clr_all),
        .tick_en  (tick_en),
        .div_val  (div_q),
        .sec_pulse(sec_pulse)
    );

    sec_rtc_counter #(.CNT_W(CNT_W)) count_i (
        .clk     (clk),
        .por     (por_rst),
        .wipe    (sys_rst && !ctrl_q.keep),
        .hold    (sys_rst),
        .load    (wr_ok && sel == SEL_TSET),
        .load_val(bus_wdata[CNT_W-1:0]),
        .inc     (sec_pulse && !ctrl_q.freeze),
        .cnt     (cnt_q)
    );

    sec_rtc_alarm #(.CNT_W(CNT_W)) alarm_i (
        .clk     (clk),
        .clr     (clr_all),
        .cnt     (cnt_q),
        .alarm   (alarm_q),
        .alarm_en(ctrl_q.alarm_en),
        .late_en (ctrl_q.late_en),
        .wake_en (ctrl_q.wake_en),
        .irq     (alarm_irq),
        .wake    (alarm_wake)
    );

    always_comb begin
        case (sel)
            SEL_CTRL:  bus_rdata = {{(32-CTRL_W){1'b0}}, ctrl_q};
            SEL_NOW:   bus_rdata = 32'(cnt_q);
            SEL_DIV:   bus_rdata = 32'(div_q);
            SEL_ALARM: bus_rdata = 32'(alarm_q);
            SEL_USER:  bus_rdata = user_q;
            SEL_RREC:  bus_rdata = {31'b0, rec_q};
            SEL_CHG:   bus_rdata = {{(32-CHG_W){1'b0}}, chg_q};
            SEL_TRIM:  bus_rdata = trim_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign chg_en       = chg_q.en;
    assign chg_no_diode = chg_q.no_diode;
    assign chg_rsel     = chg_q.rsel;
endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk
    import sec_rtc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              por_rst,
    input logic              sys_rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              alarm_irq,
    input logic              alarm_wake,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  alarm,
    input logic              alarm_en,
    input logic              freeze,
    input logic              keep,
    input logic              rec
);
    logic tset_hit;
    logic por_q;

    assign tset_hit = bus_we && (32'(bus_addr) == OFS_TSET);

    always_ff @(posedge clk) por_q <= por_rst;

    always_ff @(posedge clk) begin
        if (por_q) begin
            assert_por_clear_R1: assert (cnt == '0 && !alarm_irq && !alarm_wake)
                else $error("count or pulse not cleared by power-on reset");
        end
    end

    assert_load_R4: assert property (@(posedge clk) disable iff (por_rst)
        (tset_hit && !sys_rst) |=> (cnt == $past(bus_wdata[CNT_W-1:0])));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (por_rst)
        (!sys_rst && !tset_hit) |=> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1)));

    assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (por_rst)
        (freeze && !sys_rst && !tset_hit) |=> (cnt == $past(cnt)));

    assert_irq_armed_R7: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
        alarm_irq |-> $past(alarm_en && alarm != '0));

    assert_wake_with_irq_R9: assert property (@(posedge clk) disable iff (por_rst)
        alarm_wake |-> alarm_irq);

    assert_keep_state_R10: assert property (@(posedge clk) disable iff (por_rst)
        (sys_rst && keep) |=> (cnt == $past(cnt) && alarm == $past(alarm)));

    assert_record_set_R11: assert property (@(posedge clk) disable iff (por_rst)
        (sys_rst && keep) |=> rec);
endmodule

bind sec_rtc sec_rtc_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .por_rst   (por_rst),
    .sys_rst   (sys_rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .alarm_irq (alarm_irq),
    .alarm_wake(alarm_wake),
    .cnt       (cnt_q),
    .alarm     (alarm_q),
    .alarm_en  (ctrl_q.alarm_en),
    .freeze    (ctrl_q.freeze),
    .keep      (ctrl_q.keep),
    .rec       (rec_q)
);

// File: tb/sec_rtc_tb_top.sv
module sec_rtc_tb_top;
    localparam int DIVR = 32767;

    logic        clk = 1'b0;
    logic        por_rst = 1'b1;
    logic        sys_rst = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        alarm_irq, alarm_wake, chg_en, chg_no_diode;
    logic [1:0]  chg_rsel;

    always #5 clk = ~clk;

    sec_rtc dut_i (
        .clk(clk), .por_rst(por_rst), .sys_rst(sys_rst), .tick_en(tick_en),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .alarm_irq(alarm_irq), .alarm_wake(alarm_wake),
        .chg_en(chg_en), .chg_no_diode(chg_no_diode), .chg_rsel(chg_rsel)
    );

    int checks = 0;
    int errors = 0;
    int n_irq  = 0;
    int n_wake = 0;
    bit run    = 1'b0;

    // behavioural reference state
    logic [31:0] m_cnt, m_alarm, m_user, m_trim;
    logic [15:0] m_div, m_pre;
    logic [5:0]  m_ctrl;
    logic [3:0]  m_chg;
    logic        m_rec, m_mq, m_aq, m_irq, m_wake;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h40:   return {26'b0, m_ctrl};
            8'h44:   return m_cnt;
            8'h48:   return {16'b0, m_div};
            8'h50:   return m_alarm;
            8'h54:   return m_user;
            8'h58:   return {31'b0, m_rec};
            8'h5C:   return {28'b0, m_chg};
            8'h60:   return m_trim;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic armed, match, ev, sec, keep, wr;
        if (por_rst) begin
            m_cnt = 0; m_alarm = 0; m_user = 0; m_trim = 0; m_div = 16'(DIVR); m_pre = 0;
            m_ctrl = 0; m_chg = 0; m_rec = 0; m_mq = 0; m_aq = 0; m_irq = 0; m_wake = 0;
        end else begin
            keep  = m_ctrl[4];
            wr    = bus_we && !sys_rst;
            armed = m_ctrl[0] && (m_alarm != 0);
            match = armed && (m_cnt == m_alarm);
            ev    = (match && !m_mq) || (armed && !m_aq && m_ctrl[2] && (m_cnt > m_alarm));
            if (sys_rst) begin
                m_irq = 0; m_wake = 0; m_mq = 0; m_aq = 0;
            end else begin
                m_irq = ev; m_wake = ev && m_ctrl[1]; m_mq = match; m_aq = armed;
            end
            sec = 0;
            if (sys_rst) m_pre = 0;
            else if (tick_en) begin
                if (m_pre >= m_div) begin m_pre = 0; sec = 1; end
                else m_pre = m_pre + 1;
            end
            if (sys_rst) begin
                if (!keep) begin m_cnt = 0; m_alarm = 0; m_user = 0; end
                else m_rec = 1;
            end else begin
                if (wr && bus_addr == 8'h4C) m_cnt = bus_wdata;
                else if (sec && !m_ctrl[5]) m_cnt = m_cnt + 1;
                if (wr) begin
                    case (bus_addr)
                        8'h40: m_ctrl = (m_ctrl & ~bus_wdata[21:16]) | (bus_wdata[5:0] & bus_wdata[21:16]);
                        8'h5C: m_chg  = (m_chg & ~bus_wdata[19:16]) | (bus_wdata[3:0] & bus_wdata[19:16]);
                        8'h48: m_div  = bus_wdata[15:0];
                        8'h50: m_alarm = bus_wdata;
                        8'h54: m_user = bus_wdata;
                        8'h58: if (bus_wdata[0]) m_rec = 0;
                        8'h60: m_trim = bus_wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (run) begin
            chk("R7 model irq", {31'b0, alarm_irq}, {31'b0, m_irq});
            chk("R9 model wake", {31'b0, alarm_wake}, {31'b0, m_wake});
            chk("R3 model charger pins", {28'b0, chg_rsel, chg_no_diode, chg_en}, {28'b0, m_chg});
            chk("R12 model read", bus_rdata, m_read(bus_addr));
            if (alarm_irq) n_irq++;
            if (alarm_wake) n_wake++;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        chk(tag, bus_rdata, exp);
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic sysr(input int n);
        sys_rst = 1'b1;
        repeat (n) @(posedge clk);
        #1 sys_rst = 1'b0;
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 por_rst = 1'b0;
        run = 1'b1;
        // R1 reset state
        rd(8'h44, 32'h0, "R1 count after reset");
        rd(8'h48, 32'(DIVR), "R1 divider after reset");
        rd(8'h40, 32'h0, "R1 control after reset");
        chk("R1 irq after reset", {31'b0, alarm_irq}, 32'h0);

        // R2 masked control writes
        wr(8'h40, 32'h003F_0015);
        rd(8'h40, 32'h15, "R2 full-mask write");
        wr(8'h40, 32'h0001_0000);
        rd(8'h40, 32'h14, "R2 clear bit0 only");
        wr(8'h40, 32'h0000_003F);
        rd(8'h40, 32'h14, "R2 zero mask ignored");
        wr(8'h40, 32'h003F_0000);
        rd(8'h40, 32'h0, "R2 clear all");

        // R3 charger register and pins
        wr(8'h5C, 32'h000C_0008);
        @(negedge clk);
        chk("R3 rsel code 2", {30'b0, chg_rsel}, 32'h2);
        wr(8'h5C, 32'h0003_0003);
        rd(8'h5C, 32'hB, "R3 enable and bypass set");
        chk("R3 enable pin", {31'b0, chg_en}, 32'h1);
        wr(8'h5C, 32'h0000_000F);
        rd(8'h5C, 32'hB, "R3 unmasked write ignored");

        // R12 plain registers, holes
        wr(8'h54, 32'hDEAD_BEEF);
        rd(8'h54, 32'hDEAD_BEEF, "R12 user word");
        wr(8'h60, 32'h0000_5A5A);
        rd(8'h60, 32'h0000_5A5A, "R12 trim");
        rd(8'h64, 32'h0, "R12 undefined offset");
        rd(8'h00, 32'h0, "R12 offset zero");

        // R4 / R5 load and prescaled counting
        wr(8'h48, 32'h3);
        wr(8'h4C, 32'd10);
        rd(8'h4C, 32'h0, "R4 time-set reads zero");
        rd(8'h44, 32'd10, "R4 loaded count");
        ticks(8);
        rd(8'h44, 32'd12, "R5 two seconds from eight ticks");
        wr(8'h4C, 32'hFFFF_FFFF);
        ticks(4);
        rd(8'h44, 32'h0, "R5 wrap to zero");

        // R6 freeze
        wr(8'h4C, 32'd100);
        wr(8'h40, 32'h0020_0020);
        ticks(8);
        rd(8'h44, 32'd100, "R6 frozen count");
        wr(8'h40, 32'h0020_0000);
        ticks(4);
        rd(8'h44, 32'd101, "R6 resumes after unfreeze");

        // R7 / R9 match through counting
        wr(8'h50, 32'd105);
        wr(8'h40, 32'h0003_0003);
        n_irq = 0; n_wake = 0;
        ticks(20);
        idle(3);
        chk("R7 one pulse on counted match", n_irq, 1);
        chk("R9 wake pulse with enable", n_wake, 1);

        // R7 held match gives one pulse
        wr(8'h40, 32'h0020_0020);
        n_irq = 0;
        wr(8'h50, 32'd200);
        wr(8'h4C, 32'd200);
        idle(10);
        chk("R7 held match single pulse", n_irq, 1);

        // R7 zero alarm never fires
        n_irq = 0;
        wr(8'h50, 32'd0);
        wr(8'h4C, 32'd0);
        idle(5);
        chk("R7 zero alarm silent", n_irq, 0);

        // R9 wake disabled
        wr(8'h40, 32'h0002_0000);
        n_irq = 0; n_wake = 0;
        wr(8'h50, 32'd50);
        wr(8'h4C, 32'd50);
        idle(4);
        chk("R9 irq without wake enable", n_irq, 1);
        chk("R9 no wake when disabled", n_wake, 0);

        // R8 late arming
        wr(8'h40, 32'h0025_0000);
        wr(8'h4C, 32'd500);
        wr(8'h50, 32'd300);
        n_irq = 0;
        wr(8'h40, 32'h0005_0005);
        idle(4);
        chk("R8 late arm pulse", n_irq, 1);
        wr(8'h40, 32'h0005_0000);
        n_irq = 0;
        wr(8'h40, 32'h0001_0001);
        idle(4);
        chk("R8 no pulse without late enable", n_irq, 0);
        wr(8'h40, 32'h0001_0000);

        // R10 / R11 retention through system reset
        wr(8'h40, 32'h0010_0010);
        wr(8'h4C, 32'd777);
        wr(8'h54, 32'h0000_1234);
        wr(8'h50, 32'd999);
        sys_rst = 1'b1;
        wr(8'h54, 32'h0000_5555);
        idle(2);
        sys_rst = 1'b0;
        rd(8'h44, 32'd777, "R10 count kept");
        rd(8'h54, 32'h0000_1234, "R10 user kept, write during reset ignored");
        rd(8'h50, 32'd999, "R10 alarm kept");
        rd(8'h58, 32'h1, "R11 record set");
        wr(8'h58, 32'h0);
        rd(8'h58, 32'h1, "R11 writing zero keeps record");
        wr(8'h58, 32'h1);
        rd(8'h58, 32'h0, "R11 write one clears record");

        wr(8'h40, 32'h0010_0000);
        sysr(3);
        rd(8'h44, 32'h0, "R10 count cleared without keep");
        rd(8'h50, 32'h0, "R10 alarm cleared without keep");
        rd(8'h54, 32'h0, "R10 user cleared without keep");
        rd(8'h58, 32'h0, "R11 no record without keep");
        rd(8'h48, 32'h3, "R10 divider untouched");
        rd(8'h5C, 32'hB, "R10 charger untouched");
        rd(8'h60, 32'h0000_5A5A, "R10 trim untouched");
        rd(8'h40, 32'h0, "R10 control untouched");

        idle(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule